// File: doc/BRIEF.md
# System Management Interrupt Controller

This block sits next to a simple instruction sequencer and decides when the core enters and leaves a system management mode. An active-low request pin is synchronised and watched for falling edges. A captured request is held pending until the sequencer reports an instruction boundary while no locked bus sequence is in progress. At that point the controller asks the sequencer to run the state save, and it drives its active-low mode indicator low. The save and restore traffic itself is outside this block and is represented by two done handshakes.

While the mode is active, new requests are not delivered. One further falling edge is remembered, and any edge beyond it is discarded. The remembered request competes again only after the resume instruction has run and the restore has finished. The block also holds a base-address register. A hard reset loads this register with a fixed default. A long enough soft-reset pulse returns everything else to idle but leaves the base register untouched.

Top module: `smi_ctrl`

## Requirements
- R1: A request is raised only by a high-to-low transition of `req_n_i`. Holding `req_n_i` low produces exactly one request.
- R2: A pending request is taken only on a clock edge where `boundary_i` is high. From the next cycle, `enter_o` is high and stays high until `save_done_i` is seen.
- R3: A pending request is never taken while `locked_i` is high. It stays pending until a boundary arrives with the lock released.
- R4: While the mode is active, no second entry occurs. At most one further falling edge is held pending, and any additional edges are dropped.
- R5: A request held pending during the mode becomes eligible only after `resume_i` (in the mode) and then `restore_done_i` have both been seen.
- R6: `active_n_o` goes low in the same cycle that `enter_o` rises. It stays low through the save, the mode and the restore, and returns high in the cycle after `restore_done_i`.
- R7: `base_load_i` writes `base_data_i` into the base register. A hard reset (`rst_n` low) loads `BASE_DEFAULT` (default 0x00030000). `resume_i`, `save_done_i` and `restore_done_i` have no effect outside their own phase.
- R8: A soft reset takes effect only if `soft_rst_i` stays high for at least `SOFT_MIN` (15) consecutive cycles. It returns the controller to idle with `active_n_o` high and clears any pending request, while the base register keeps its value. A shorter pulse changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous assert, active low |
| soft_rst_i | input | 1 | Soft reset request, active high, asynchronous |
| req_n_i | input | 1 | Management request, falling-edge triggered, asynchronous |
| boundary_i | input | 1 | Instruction-boundary strobe from the sequencer |
| locked_i | input | 1 | Locked bus sequence in progress |
| resume_i | input | 1 | Resume instruction executed |
| save_done_i | input | 1 | State save finished |
| restore_done_i | input | 1 | Last restore cycle finished |
| base_load_i | input | 1 | Write strobe for the base register |
| base_data_i | input | AW | Value written into the base register |
| enter_o | output | 1 | Request to the sequencer to run the save sequence |
| active_n_o | output | 1 | Mode active, active low |
| base_o | output | AW | Current base-address register |

## Verification
The bench goes after the corners where a request could be taken at the wrong time.

- **Boundary and lock:** it sweeps the boundary and lock combinations with a request pending. A controller that looked at the lock too late would enter in the middle of a locked sequence.
- **Level versus edge:** it holds the request pin low across a whole mode visit. A level-sensitive design would enter a second time.
- **Nested requests:** it sends two edges during the mode and expects exactly one extra entry afterwards. Counting edges instead of flagging one would enter twice, and ignoring the nested edge would never re-enter.
- **Soft reset:** it applies pulses of 14 and 15 cycles. A filter that is off by one would honour the short pulse or miss the long one, and a soft reset that cleared the base register shows up at `base_o`.

// File: rtl/smi_pkg.sv
package smi_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SAVE    = 2'd1,
    PH_MODE    = 2'd2,
    PH_RESTORE = 2'd3
  } smi_phase_e;
endpackage

// File: rtl/smi_edge_det.sv
module smi_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q, last_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_n_i};
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign fall_o = last_q & ~sync_q[STAGES-1];

  // R1
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/smi_soft_filter.sv
module smi_soft_filter #(
  parameter int STAGES   = 2,
  parameter int SOFT_MIN = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_i,
  output logic hit_o
);
  localparam int CW = $clog2(SOFT_MIN + 1);

  logic [STAGES-1:0] sync_q, sync_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              cnt_en;
  logic              level;

  assign level = sync_q[STAGES-1];

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], soft_i};
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!level) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (cnt_q != CW'(SOFT_MIN)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign hit_o = level && (cnt_q == CW'(SOFT_MIN - 1));

  // R8
  soft_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> !hit_o);
endmodule

// File: rtl/smi_phase_fsm.sv
module smi_phase_fsm
  import smi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_clr_i,
  input  logic       fall_i,
  input  logic       boundary_i,
  input  logic       locked_i,
  input  logic       resume_i,
  input  logic       save_done_i,
  input  logic       restore_done_i,
  output smi_phase_e phase_o,
  output logic       pending_o
);
  smi_phase_e phase_q, phase_d;
  logic       pend_q, pend_d;
  logic       take;

  always_comb begin
    take    = (phase_q == PH_IDLE) && pend_q && boundary_i && !locked_i;
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:    if (take)           phase_d = PH_SAVE;
      PH_SAVE:    if (save_done_i)    phase_d = PH_MODE;
      PH_MODE:    if (resume_i)       phase_d = PH_RESTORE;
      PH_RESTORE: if (restore_done_i) phase_d = PH_IDLE;
      default:                        phase_d = PH_IDLE;
    endcase
    // Only one request is held; extra edges while one is held are lost.
    pend_d = take ? fall_i : (pend_q | fall_i);
    if (soft_clr_i) begin
      phase_d = PH_IDLE;
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pend_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pend_q  <= pend_d;
    end
  end

  assign phase_o   = phase_q;
  assign pending_o = pend_q;

  // R4
  no_nested_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_MODE || phase_q == PH_RESTORE) |=> (phase_q != PH_SAVE));

  // R5
  exit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && $past(phase_q) != PH_IDLE && !$past(soft_clr_i))
      |-> $past(phase_q) == PH_RESTORE && $past(restore_done_i));
endmodule

// File: rtl/smi_ctrl.sv
module smi_ctrl
  import smi_pkg::*;
#(
  parameter int          AW           = 32,
  parameter logic [31:0] BASE_DEFAULT = 32'h0003_0000,
  parameter int          SOFT_MIN     = 15,
  parameter int          SYNC_STAGES  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst_i,
  input  logic          req_n_i,
  input  logic          boundary_i,
  input  logic          locked_i,
  input  logic          resume_i,
  input  logic          save_done_i,
  input  logic          restore_done_i,
  input  logic          base_load_i,
  input  logic [AW-1:0] base_data_i,
  output logic          enter_o,
  output logic          active_n_o,
  output logic [AW-1:0] base_o
);
  logic [1:0]    rsync_q;
  logic          rst_int_n;
  logic          fall;
  logic          soft_hit;
  logic          pending;
  smi_phase_e    phase;
  logic [AW-1:0] base_q, base_d;
  logic          base_en;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  smi_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .pin_n_i (req_n_i),
    .fall_o  (fall)
  );

  smi_soft_filter #(.STAGES(SYNC_STAGES), .SOFT_MIN(SOFT_MIN)) u_soft (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .soft_i (soft_rst_i),
    .hit_o  (soft_hit)
  );

  smi_phase_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .soft_clr_i     (soft_hit),
    .fall_i         (fall),
    .boundary_i     (boundary_i),
    .locked_i       (locked_i),
    .resume_i       (resume_i),
    .save_done_i    (save_done_i),
    .restore_done_i (restore_done_i),
    .phase_o        (phase),
    .pending_o      (pending)
  );

  always_comb begin
    base_en = base_load_i;
    base_d  = base_data_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   base_q <= BASE_DEFAULT[AW-1:0];
    else if (base_en) base_q <= base_d;
  end

  assign base_o     = base_q;
  assign enter_o    = (phase == PH_SAVE);
  assign active_n_o = (phase == PH_IDLE);

  // R2
  entry_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(enter_o) |-> $past(boundary_i) && $past(pending));

  // R3
  entry_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(enter_o) |-> !$past(locked_i));

  // R6
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!active_n_o && !restore_done_i && !soft_hit) |=> !active_n_o);

  // R6
  active_with_enter_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    enter_o |-> !active_n_o);

  // R8
  soft_keeps_base_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (soft_hit && !base_load_i) |=> $stable(base_o));
endmodule

// File: tb/smi_ctrl_tb.sv
module smi_ctrl_tb;
  localparam logic [31:0] DEF = 32'h0003_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst_i = 1'b0;
  logic        req_n_i = 1'b1;
  logic        boundary_i = 1'b0;
  logic        locked_i = 1'b0;
  logic        resume_i = 1'b0;
  logic        save_done_i = 1'b0;
  logic        restore_done_i = 1'b0;
  logic        base_load_i = 1'b0;
  logic [31:0] base_data_i = '0;
  logic        enter_o, active_n_o;
  logic [31:0] base_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  smi_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i), .req_n_i(req_n_i),
    .boundary_i(boundary_i), .locked_i(locked_i), .resume_i(resume_i),
    .save_done_i(save_done_i), .restore_done_i(restore_done_i),
    .base_load_i(base_load_i), .base_data_i(base_data_i),
    .enter_o(enter_o), .active_n_o(active_n_o), .base_o(base_o)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edge_req();
    req_n_i = 1'b0; tick(4);
    req_n_i = 1'b1; tick(4);
  endtask

  task automatic strobe_boundary();
    boundary_i = 1'b1; tick(1); boundary_i = 1'b0;
  endtask

  task automatic strobe_save();
    save_done_i = 1'b1; tick(1); save_done_i = 1'b0;
  endtask

  task automatic strobe_resume();
    resume_i = 1'b1; tick(1); resume_i = 1'b0;
  endtask

  task automatic strobe_restore();
    restore_done_i = 1'b1; tick(1); restore_done_i = 1'b0;
  endtask

  task automatic full_visit();
    strobe_save(); tick(2); strobe_resume(); tick(2); strobe_restore(); tick(1);
  endtask

  task automatic hard_reset();
    rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(4);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    hard_reset();
    // R7: reset state
    check(active_n_o, 1, "R7 reset active_n");
    check(enter_o, 0, "R7 reset enter");
    check(base_o, DEF, "R7 reset base default");

    // R2: boundary with nothing pending
    strobe_boundary();
    check(enter_o, 0, "R2 boundary without request");

    // R2: request pending, no boundary
    edge_req(); tick(6);
    check(enter_o, 0, "R2 no boundary no entry");

    // R2 R3: sweep of boundary/lock with one request pending
    for (int c = 0; c < 3; c++) begin
      boundary_i = (c != 0);
      locked_i   = (c != 2) ? 1'b1 : 1'b0;
      if (c == 2) boundary_i = 1'b0;
      tick(1);
      boundary_i = 1'b0; locked_i = 1'b0;
      check(enter_o, 0, "R3 locked or no boundary");
    end
    strobe_boundary();
    check(enter_o, 1, "R2 entry at unlocked boundary");
    check(active_n_o, 0, "R6 active low at entry");
    tick(3);
    check(enter_o, 1, "R2 enter held until save done");

    // R7: done strobes outside phase ignored
    strobe_restore(); strobe_resume();
    check(enter_o, 1, "R7 restore/resume ignored during save");

    strobe_save();
    check(enter_o, 0, "R6 enter drops after save");
    check(active_n_o, 0, "R6 active during mode");

    // R4: two edges during mode, boundary ignored
    edge_req(); edge_req();
    strobe_boundary();
    check(enter_o, 0, "R4 no entry while active");
    strobe_restore();
    check(active_n_o, 0, "R7 restore ignored in mode");
    strobe_resume();
    check(active_n_o, 0, "R6 active during restore");
    strobe_boundary();
    check(enter_o, 0, "R5 pending not taken before restore done");
    strobe_restore();
    check(active_n_o, 1, "R6 active released after restore");

    // R5: nested request taken once, second edge dropped
    strobe_boundary();
    check(enter_o, 1, "R5 nested request delivered after exit");
    full_visit();
    check(active_n_o, 1, "R6 second visit exited");
    strobe_boundary();
    check(enter_o, 0, "R4 third edge was dropped");

    // R1: level held low gives exactly one request
    req_n_i = 1'b0; tick(5);
    strobe_boundary();
    check(enter_o, 1, "R1 falling edge delivers");
    full_visit();
    tick(4);
    strobe_boundary();
    check(enter_o, 0, "R1 held level not re-delivered");
    req_n_i = 1'b1; tick(4);
    strobe_boundary();
    check(enter_o, 0, "R1 rising edge ignored");

    // R7: base load
    base_data_i = 32'hA5A5_0000; base_load_i = 1'b1; tick(1); base_load_i = 1'b0;
    check(base_o, 32'hA5A5_0000, "R7 base load");

    // R8: enter mode, leave a request pending, short soft pulse
    edge_req(); strobe_boundary(); strobe_save();
    edge_req();
    soft_rst_i = 1'b1; tick(14); soft_rst_i = 1'b0; tick(6);
    check(active_n_o, 0, "R8 14-cycle soft reset ignored");
    soft_rst_i = 1'b1; tick(15); soft_rst_i = 1'b0; tick(6);
    check(active_n_o, 1, "R8 15-cycle soft reset honoured");
    check(base_o, 32'hA5A5_0000, "R8 soft reset keeps base");
    strobe_boundary();
    check(enter_o, 0, "R8 soft reset cleared pending");

    // R7: hard reset restores default
    hard_reset();
    check(base_o, DEF, "R7 hard reset base default");
    check(active_n_o, 1, "R7 hard reset idle");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule